// File: doc/BRIEF.md
# Triggered Post-Event Sample Recorder

This block is a small on-chip logic analyzer engine. It watches two probe inputs, a single-bit probe and an eight-bit probe bus, on every rising edge of its clock. Once software has armed it, it waits for a programmable trigger pattern on those probes. On the first matching edge it starts recording, and it stores a fixed window of consecutive samples into an internal memory. The probes themselves are the recorded data.

The trigger pattern is a match value plus a per-bit don't-care mask for each probe. The trigger fires only when both probes match. When the window is full, the recorder parks in a done state. A host then drains the memory through a strobe-driven sequential read port, and the samples come back in the order they were captured. Three status outputs give the progress: armed, triggered and done. An abort input drops the recorder back to idle at any time.

Top module: `probe_capture`

## Requirements
- R1: After a synchronous active-low reset, `st_armed`, `st_triggered`, `st_done` and `rd_valid` are 0 and `rd_data` is 0.
- R2: A trigger match has no effect unless the recorder is armed. While idle or done, matching probe values leave `st_triggered` low and leave the recorded data unchanged.
- R3: An `arm` pulse with `abort` low moves the recorder to the armed state on that edge, from any state. It clears `st_done` and resets both the write address and the read pointer.
- R4: The single-bit probe matches when it equals `match_bit` or `mask_bit` is 1. The bus matches when every bit equals `match_bus` or has a 1 in `mask_bus`. The trigger is the AND of both matches, so fully masked probes trigger on the first armed edge.
- R5: The trigger sample is stored as sample 0. The recorder then stores DEPTH consecutive samples. Each sample has the single-bit probe in bit 8 and the probe bus in bits 7:0.
- R6: `st_triggered` is high from the trigger edge onward. `st_done` goes high on the edge that stores sample DEPTH-1, and at that edge `st_armed` drops.
- R7: `st_done` stays high until the next `arm` or `abort`.
- R8: In the done state, each edge with `rd_strobe` high returns the next stored sample on `rd_data` one cycle later, with `rd_valid` high. The read pointer wraps from DEPTH-1 back to sample 0.
- R9: A read strobe outside the done state returns 0 with `rd_valid` high, and it does not advance the read pointer.
- R10: `abort` returns the recorder to idle on the next edge from any state, with all status outputs low, and it takes priority over `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Arm command pulse |
| abort | input | 1 | Return to idle |
| match_bit | input | 1 | Match value for the single-bit probe |
| mask_bit | input | 1 | Don't-care for the single-bit probe (1 = ignore) |
| match_bus | input | 8 | Match value for the probe bus |
| mask_bus | input | 8 | Per-bit don't-care for the probe bus (1 = ignore) |
| probe_bit | input | 1 | Single-bit probe, trigger and data |
| probe_bus | input | 8 | Eight-bit probe, trigger and data |
| rd_strobe | input | 1 | Read the next stored sample |
| rd_data | output | 9 | Read sample, {probe_bit, probe_bus} |
| rd_valid | output | 1 | `rd_data` updated by the previous strobe |
| st_armed | output | 1 | Waiting for the trigger |
| st_triggered | output | 1 | Trigger seen, capturing or finished |
| st_done | output | 1 | Window complete, memory readable |

## Verification
A wrong control state shows at the status outputs one cycle after the edge that caused it. A recorder that triggers too early, too late or while unarmed either shifts every read sample by whole positions or raises `st_triggered` at a cycle the bench can predict exactly. A wrong write address or a wrong read pointer shows as a mismatch on the first drained sample that it touches. A miscounted window shows as `st_done` one edge early or late. Running several trigger patterns, including exact bus values, partial masks and fully masked probes, and draining past the wrap point exposes each of these within a single capture.

// File: rtl/cap_pkg.sv
// Package: shared types for the triggered sample recorder.
// Assumes: single clock domain; probe widths are fixed by the block's function.
package cap_pkg;
    localparam int BIT_W    = 1;
    localparam int BUS_W    = 8;
    localparam int SAMPLE_W = BIT_W + BUS_W;
    localparam int MAX_DEPTH = 16384;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2,
        CAP_DONE  = 2'd3
    } cap_state_e;
endpackage

// File: rtl/cap_match.sv
// Module: masked comparator for one probe.
// Reports a hit when every unmasked bit of the value equals the match value.
// Assumes: mask bit 1 means don't care; purely combinational.
module cap_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] match,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] bit_ok;

    // Per-bit agreement, forced true where masked.
    always_comb begin
        bit_ok = ~(value ^ match) | mask;
        hit    = &bit_ok;
    end
endmodule

// File: rtl/cap_ctrl.sv
// Module: arm/trigger/capture sequencer.
// Walks idle -> armed -> running -> done, generates the write strobe and address.
// Assumes: abort has priority over arm; arm is accepted in every state.
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          abort,
    input  logic          hit,
    output cap_state_e    state,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    cap_state_e    state_q;
    logic [AW-1:0] waddr_q;
    logic          cmd_quiet;

    // Commands suppress writes on the edge they take effect.
    always_comb begin
        cmd_quiet = !arm && !abort;
        wr_en     = cmd_quiet &&
                    (((state_q == CAP_ARMED) && hit) || (state_q == CAP_RUN));
        wr_addr   = waddr_q;
        state     = state_q;
    end

    // Sequencer state and write address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            waddr_q <= '0;
        end else if (abort) begin
            state_q <= CAP_IDLE;
        end else if (arm) begin
            state_q <= CAP_ARMED;
            waddr_q <= '0;
        end else begin
            case (state_q)
                CAP_ARMED: begin
                    if (hit) begin
                        if (DEPTH == 1) begin
                            state_q <= CAP_DONE;
                        end else begin
                            state_q <= CAP_RUN;
                            waddr_q <= waddr_q + 1'b1;
                        end
                    end
                end
                CAP_RUN: begin
                    if (waddr_q == LAST) begin
                        state_q <= CAP_DONE;
                    end else begin
                        waddr_q <= waddr_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == CAP_IDLE));

    // R3
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !abort) |=> ((state_q == CAP_ARMED) && (waddr_q == '0)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CAP_IDLE) && !arm) |=> (state_q == CAP_IDLE));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CAP_DONE) && !arm && !abort) |=> (state_q == CAP_DONE));

    // R6
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == CAP_DONE) |->
            ($past(state_q == CAP_RUN) || $past(state_q == CAP_ARMED)));

    // R5
    wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/cap_buffer.sv
// Module: sample memory with strobe-driven sequential readout.
// Writes one sample per enabled edge; reads return one cycle after the strobe.
// Assumes: memory contents are not reset; reads are gated by rd_enable.
module cap_buffer #(
    parameter int DEPTH = 1024,
    parameter int W     = 9,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_clear,
    input  logic          rd_enable,
    input  logic          rd_strobe,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rptr_q;
    logic [W-1:0]  rdata_q;
    logic          rvalid_q;

    // Sample storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Sequential read pointer, read data and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q   <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_strobe;
            if (rd_strobe) begin
                if (rd_enable) begin
                    rdata_q <= mem[rptr_q];
                    rptr_q  <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
                end else begin
                    rdata_q <= '0;
                end
            end
            if (rd_clear) begin
                rptr_q <= '0;
            end
        end
    end

    always_comb begin
        rd_data  = rdata_q;
        rd_valid = rvalid_q;
    end

    // R9
    early_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rd_enable) |=> (rd_data == '0));

    // R9
    early_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rd_enable && !rd_clear) |=> $stable(rptr_q));
endmodule

// File: rtl/probe_capture.sv
// Module: top of the triggered sample recorder.
// Compares both probes against masked match values, records DEPTH samples from
// the trigger edge onward, and drains them in order through a read strobe.
// Assumes: one clock; control inputs are synchronous to clk.
module probe_capture
    import cap_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic                 abort,
    input  logic                 match_bit,
    input  logic                 mask_bit,
    input  logic [BUS_W-1:0]     match_bus,
    input  logic [BUS_W-1:0]     mask_bus,
    input  logic                 probe_bit,
    input  logic [BUS_W-1:0]     probe_bus,
    input  logic                 rd_strobe,
    output logic [SAMPLE_W-1:0]  rd_data,
    output logic                 rd_valid,
    output logic                 st_armed,
    output logic                 st_triggered,
    output logic                 st_done
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          hit_bit;
    logic          hit_bus;
    logic          hit;
    cap_state_e    state;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [SAMPLE_W-1:0] sample;

    cap_match #(.W(BIT_W)) u_match_bit (
        .value (probe_bit),
        .match (match_bit),
        .mask  (mask_bit),
        .hit   (hit_bit)
    );

    cap_match #(.W(BUS_W)) u_match_bus (
        .value (probe_bus),
        .match (match_bus),
        .mask  (mask_bus),
        .hit   (hit_bus)
    );

    // Combined trigger and sample word.
    always_comb begin
        hit    = hit_bit && hit_bus;
        sample = {probe_bit, probe_bus};
    end

    cap_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .abort   (abort),
        .hit     (hit),
        .state   (state),
        .wr_en   (wr_en),
        .wr_addr (wr_addr)
    );

    cap_buffer #(.DEPTH(DEPTH), .W(SAMPLE_W), .AW(AW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (sample),
        .rd_clear  (arm || abort),
        .rd_enable (state == CAP_DONE),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // Status decode.
    always_comb begin
        st_armed     = (state == CAP_ARMED);
        st_triggered = (state == CAP_RUN) || (state == CAP_DONE);
        st_done      = (state == CAP_DONE);
    end

    // R2
    unarmed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_armed && !st_triggered && !arm) |=> !st_triggered);

    // R6
    armed_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_armed && hit && !arm && !abort) |=> st_triggered);
endmodule

// File: tb/probe_capture_tb.sv
module probe_capture_tb;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic       abort = 1'b0;
    logic       match_bit = 1'b0;
    logic       mask_bit = 1'b1;
    logic [7:0] match_bus = 8'h00;
    logic [7:0] mask_bus = 8'hFF;
    logic       probe_bit = 1'b0;
    logic [7:0] probe_bus = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [8:0] rd_data;
    logic       rd_valid;
    logic       st_armed;
    logic       st_triggered;
    logic       st_done;

    int total = 0;
    int bad = 0;
    logic [8:0] exp_s [DEPTH];

    always #5 clk = ~clk;

    probe_capture #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort),
        .match_bit(match_bit), .mask_bit(mask_bit),
        .match_bus(match_bus), .mask_bus(mask_bus),
        .probe_bit(probe_bit), .probe_bus(probe_bus),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_valid(rd_valid),
        .st_armed(st_armed), .st_triggered(st_triggered), .st_done(st_done)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Trigger rule written from the requirement: equal or masked, both probes.
    function automatic bit would_hit(input logic b, input logic [7:0] v);
        bit ok;
        ok = mask_bit || (b == match_bit);
        for (int i = 0; i < 8; i++)
            if (!mask_bus[i] && (v[i] != match_bus[i])) ok = 0;
        return ok;
    endfunction

    task automatic status_is(input logic a, input logic t, input logic d, input string tag);
        check(32'(st_armed), 32'(a), {tag, " armed"});
        check(32'(st_triggered), 32'(t), {tag, " triggered"});
        check(32'(st_done), 32'(d), {tag, " done"});
    endtask

    // Arms, drives a stimulus pattern, records the expected window.
    task automatic run_capture(input int start, input int step, input int bitper, input int binv);
        bit trig;
        int idx;
        logic b;
        logic [7:0] v;
        trig = 0;
        idx = 0;
        @(negedge clk);
        arm = 1'b1;
        for (int c = 0; c < 600 && idx < DEPTH; c++) begin
            @(negedge clk);
            if (c == 0) begin
                arm = 1'b0;
                check(32'(st_armed), 1, "R3 armed after arm");
                check(32'(st_done), 0, "R3 done cleared by arm");
            end
            if (trig && idx == 1) begin
                check(32'(st_triggered), 1, "R6 triggered after trigger edge");
                check(32'(st_done), 0, "R6 not done during window");
            end
            b = 1'(((c / bitper) % 2) ^ binv);
            v = 8'(start + c * step);
            probe_bit = b;
            probe_bus = v;
            if (!trig && would_hit(b, v)) begin
                trig = 1;
                check(32'(st_triggered), 0, "R4 no trigger before match");
            end
            if (trig) begin
                exp_s[idx] = {b, v};
                idx++;
            end
        end
        check(32'(trig), 1, "R4 trigger found");
        check(32'(st_done), 0, "R6 done not early");
        @(negedge clk);
        status_is(1'b0, 1'b1, 1'b1, "R6 window end");
    endtask

    // Drains n samples, expects capture order with wrap.
    task automatic read_n(input int n, input int first);
        @(negedge clk);
        rd_strobe = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n - 1) rd_strobe = 1'b0;
            check(32'(rd_valid), 1, "R8 valid");
            check(32'(rd_data), 32'(exp_s[(first + i) % DEPTH]), "R5 R8 sample order");
        end
    endtask

    task automatic read_zero(input int n, input string tag);
        @(negedge clk);
        rd_strobe = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n - 1) rd_strobe = 1'b0;
            check(32'(rd_valid), 1, {tag, " valid"});
            check(32'(rd_data), 0, {tag, " zero"});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        status_is(1'b0, 1'b0, 1'b0, "R1 reset");
        check(32'(rd_valid), 0, "R1 rd_valid");
        check(32'(rd_data), 0, "R1 rd_data");

        // R2: fully masked pattern matches, but unit is idle
        repeat (5) begin
            @(negedge clk);
            probe_bus = probe_bus + 8'd1;
        end
        status_is(1'b0, 1'b0, 1'b0, "R2 idle ignores match");

        // R9: reads before done return zero
        read_zero(3, "R9 early read");

        // R4 R5: falling single-bit probe, bus masked out
        match_bit = 1'b0; mask_bit = 1'b0; mask_bus = 8'hFF;
        run_capture(16, 1, 5, 1);
        read_n(DEPTH + 1, 0);  // wrap returns sample 0 (R8)

        // R7: done holds while matches keep arriving (R2)
        repeat (8) begin
            @(negedge clk);
            probe_bit = ~probe_bit;
        end
        status_is(1'b0, 1'b1, 1'b1, "R7 done holds");
        read_n(2, 1);  // pointer continues after wrap; data untouched (R2)

        // R4: exact bus matches, single-bit probe masked
        mask_bit = 1'b1; mask_bus = 8'h00;
        for (int m = 0; m < 256; m += 51) begin
            match_bus = 8'(m);
            run_capture(m - 7, 1, 3, 0);
            read_n(DEPTH, 0);
        end

        // R4: partial mask, both probes must agree
        match_bit = 1'b1; mask_bit = 1'b0;
        match_bus = 8'h30; mask_bus = 8'h0F;
        run_capture(0, 3, 2, 0);
        read_n(DEPTH, 0);

        // R4: fully masked triggers on first armed edge
        mask_bit = 1'b1; mask_bus = 8'hFF;
        run_capture(200, 5, 1, 0);
        read_n(DEPTH, 0);

        // R3: arm from done clears done
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        status_is(1'b1, 1'b1 && 1'b0, 1'b0, "R3 rearm from done");

        // R10: abort from armed
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        status_is(1'b0, 1'b0, 1'b0, "R10 abort from armed");
        read_zero(2, "R9 read after abort");

        // R10: abort mid-capture, then idle ignores matches (R2)
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        repeat (4) @(negedge clk);
        status_is(1'b0, 1'b1, 1'b0, "R6 capturing");
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        status_is(1'b0, 1'b0, 1'b0, "R10 abort mid-capture");
        repeat (DEPTH + 2) @(negedge clk);
        status_is(1'b0, 1'b0, 1'b0, "R2 idle after abort");

        // R10: abort wins over arm in the same cycle
        @(negedge clk); arm = 1'b1; abort = 1'b1;
        @(negedge clk); arm = 1'b0; abort = 1'b0;
        status_is(1'b0, 1'b0, 1'b0, "R10 abort priority");

        // R3: arm during capture restarts
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        repeat (3) @(negedge clk);
        mask_bus = 8'h00; match_bus = 8'hEE; probe_bus = 8'h00;
        arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        status_is(1'b1, 1'b0, 1'b0, "R3 rearm mid-capture");

        // R1: reset returns everything to idle
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        status_is(1'b0, 1'b0, 1'b0, "R1 reset again");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule